// File: doc/BRIEF.md
# Generalized Signed Full Adder Cell

This cell adds three single-bit inputs whose weights may be positive or negative and returns a weighted two-bit result: an intermediate sum bit and a carry bit. Each output also carries its own sign. Redundant signed digit adders use it as their basic element. A digit there is held as a pair of bits, one with positive weight and one with negative weight. Several such cells, placed in two layers, absorb carries locally instead of rippling them along the word.

The parameter `TYPE` (1 to 4) chooses which inputs and outputs are negatively weighted. Type 1 counts `in_y` as negative and reports the sum bit as negative. The other types move the negative weights to other positions. All types share one gate structure, made of two independent sub-circuits that see only the three inputs:
- The parity chain is two cascaded XOR-type gates.
- The carry network is three two-input AND terms feeding one three-input OR.

The types differ only in where the inverters sit. The parameter `REG_OUT` adds a flop stage on both outputs.

Top module: `gsfa_cell`

## Requirements
- R1: With TYPE=1, every one of the 8 input vectors satisfies in_x − in_y + in_z = 2·carry_o − sum_o.
- R2: With TYPE=1, sum_o equals (in_x XOR NOT in_y) XOR NOT in_z.
- R3: With TYPE=1, carry_o equals (in_x AND NOT in_y) OR (NOT in_y AND in_z) OR (in_z AND in_x).
- R4: With TYPE=2, every input vector satisfies −in_x + in_y + in_z = 2·carry_o − sum_o.
- R5: With TYPE=3, every input vector satisfies −in_x − in_y + in_z = sum_o − 2·carry_o.
- R6: With TYPE=4, every input vector satisfies −in_x − in_y − in_z = −2·carry_o − sum_o.
- R7: With REG_OUT=0, the outputs follow the inputs with no clock edge, and a low rst_n has no effect on them.
- R8: With REG_OUT=1, the outputs take the value computed from the inputs sampled at a rising clk edge. They hold that value when the inputs change between edges.
- R9: With REG_OUT=1, the reset is synchronous and active-low. A rising edge with rst_n low clears sum_o and carry_o to 0. Pulling rst_n low between edges leaves the outputs unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset of the output stage |
| in_x | input | 1 | First operand bit |
| in_y | input | 1 | Second operand bit |
| in_z | input | 1 | Third operand bit |
| sum_o | output | 1 | Intermediate sum bit, signed as the type defines |
| carry_o | output | 1 | Carry bit of weight two, signed as the type defines |

## Verification
The bench checks every type over all eight input vectors, because each type is wrong on only some of them:
- A misplaced inverter on one input breaks the weighted relation on exactly the vectors where that input differs.
- A carry term with the wrong polarity fails only where the two inputs of that term disagree.

For Type 1, the bench also compares both outputs bit-for-bit against the gate equations. A parity chain that inverts its second operand in the wrong place would still match the carry but fail the sum.

For the registered variant, the bench pulls reset low mid-cycle while both outputs are 1. An asynchronous reset would clear them before the edge. It also changes the inputs mid-cycle. A transparent stage would then show the new value instead of holding the old one.

// File: rtl/gsfa_pkg.sv
// Package: shared configuration type for the signed full adder cell.
// Assumes the cell type number lies in 1..4; any other value falls back to type 1.
package gsfa_pkg;

    typedef struct packed {
        logic neg_x;   // in_x carries negative weight
        logic neg_y;   // in_y carries negative weight
        logic neg_z;   // in_z carries negative weight
        logic inv_s;   // sum bit is reported with negative weight
        logic inv_c;   // carry bit is reported with negative weight
    } cell_cfg_t;

    // Derive the inversion pattern from the type number.
    function automatic cell_cfg_t cfg_for(input int cell_type);
        cell_cfg_t cfg;
        int        nneg;
        cfg = '0;
        case (cell_type)
            2:       begin cfg.neg_x = 1'b1; end
            3:       begin cfg.neg_x = 1'b1; cfg.neg_y = 1'b1; end
            4:       begin cfg.neg_x = 1'b1; cfg.neg_y = 1'b1; cfg.neg_z = 1'b1; end
            default: begin cfg.neg_y = 1'b1; end
        endcase
        nneg      = int'(cfg.neg_x) + int'(cfg.neg_y) + int'(cfg.neg_z);
        cfg.inv_s = (nneg % 2) == 1;
        cfg.inv_c = nneg >= 2;
        return cfg;
    endfunction

    // Signed weighted value of the three inputs.
    function automatic int lhs_value(input cell_cfg_t cfg, input logic x,
                                     input logic y, input logic z);
        int vx;
        int vy;
        int vz;
        vx = cfg.neg_x ? -int'(x) : int'(x);
        vy = cfg.neg_y ? -int'(y) : int'(y);
        vz = cfg.neg_z ? -int'(z) : int'(z);
        return vx + vy + vz;
    endfunction

    // Signed weighted value of the two outputs.
    function automatic int rhs_value(input cell_cfg_t cfg, input logic s,
                                     input logic c);
        int vs;
        int vc;
        vs = cfg.inv_s ? -int'(s) : int'(s);
        vc = cfg.inv_c ? -2 * int'(c) : 2 * int'(c);
        return vc + vs;
    endfunction

endpackage

// File: rtl/gsfa_sum_path.sv
// Module: parity chain producing the intermediate sum bit.
// Two cascaded XOR-type gates; input and output inversions come from CFG.
// Assumes: purely combinational, shares only the primary inputs with the carry network.
module gsfa_sum_path #(
    parameter gsfa_pkg::cell_cfg_t CFG = gsfa_pkg::cfg_for(1)
) (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic s_o
);

    logic xa, ya, za;
    logic stage1;

    // Map each input into the all-positive domain.
    always_comb begin
        xa = x_i ^ CFG.neg_x;
        ya = y_i ^ CFG.neg_y;
        za = z_i ^ CFG.neg_z;
    end

    // First gate combines x and y, second folds in z and the output sign.
    always_comb begin
        stage1 = xa ^ ya;
        s_o    = stage1 ^ (za ^ CFG.inv_s);
    end

    // Sum must reflect the odd/even count of positive-domain ones.
    always_comb begin
        AST_SUM_PARITY: assert (s_o == ((($countones({xa, ya, za}) % 2) == 1) ^ CFG.inv_s)); // R2
    end

endmodule

// File: rtl/gsfa_carry_path.sv
// Module: carry network of three two-input AND terms and one three-input OR.
// Settles within two gate levels; inversions come from CFG.
// Assumes: purely combinational, independent of the parity chain.
module gsfa_carry_path #(
    parameter gsfa_pkg::cell_cfg_t CFG = gsfa_pkg::cfg_for(1)
) (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic c_o
);

    logic xa, ya, za;
    logic t_xy, t_yz, t_zx;

    // Map each input into the all-positive domain.
    always_comb begin
        xa = x_i ^ CFG.neg_x;
        ya = y_i ^ CFG.neg_y;
        za = z_i ^ CFG.neg_z;
    end

    // First level: the three pairwise AND terms.
    always_comb begin
        t_xy = xa & ya;
        t_yz = ya & za;
        t_zx = za & xa;
    end

    // Second level: three-input OR plus the output sign.
    always_comb begin
        c_o = (t_xy | t_yz | t_zx) ^ CFG.inv_c;
    end

    // Carry must mark "two or more positive-domain ones".
    always_comb begin
        AST_CARRY_MAJORITY: assert (c_o == (($countones({xa, ya, za}) >= 2) ^ CFG.inv_c)); // R3
    end

endmodule

// File: rtl/gsfa_out_stage.sv
// Module: optional output flop stage for the sum and carry bits.
// REG_OUT=1 gives flops with a synchronous active-low reset to zero;
// REG_OUT=0 passes the bits straight through.
// Assumes: rst_n is synchronous to clk.
module gsfa_out_stage #(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_d,
    input  logic c_d,
    output logic s_q,
    output logic c_q
);

    generate
        if (REG_OUT) begin : g_reg
            // Capture both bits on the rising edge, clearing them under reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_q <= 1'b0;
                    c_q <= 1'b0;
                end else begin
                    s_q <= s_d;
                    c_q <= c_d;
                end
            end

            AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (s_q == $past(s_d) && c_q == $past(c_d))); // R8

            AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (s_q == 1'b0 && c_q == 1'b0)); // R9
        end else begin : g_comb
            // Straight-through path, no storage.
            always_comb begin
                s_q = s_d;
                c_q = c_d;
            end
        end
    endgenerate

endmodule

// File: rtl/gsfa_cell.sv
// Module: generalized signed full adder cell (top).
// TYPE selects the negative-weight pattern; REG_OUT adds an output flop stage.
// Assumes: TYPE in 1..4; clk and rst_n only matter when REG_OUT=1.
module gsfa_cell #(
    parameter int TYPE    = 1,
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_x,
    input  logic in_y,
    input  logic in_z,
    output logic sum_o,
    output logic carry_o
);

    localparam gsfa_pkg::cell_cfg_t CFG = gsfa_pkg::cfg_for(TYPE);

    logic sum_d;
    logic carry_d;

    gsfa_sum_path #(.CFG(CFG)) u_sum (
        .x_i (in_x),
        .y_i (in_y),
        .z_i (in_z),
        .s_o (sum_d)
    );

    gsfa_carry_path #(.CFG(CFG)) u_carry (
        .x_i (in_x),
        .y_i (in_y),
        .z_i (in_z),
        .c_o (carry_d)
    );

    gsfa_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .s_d   (sum_d),
        .c_d   (carry_d),
        .s_q   (sum_o),
        .c_q   (carry_o)
    );

    // Weighted value of the two independent paths must equal that of the inputs.
    AST_WEIGHT_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
        gsfa_pkg::lhs_value(CFG, in_x, in_y, in_z) ==
        gsfa_pkg::rhs_value(CFG, sum_d, carry_d)); // R1

endmodule

// File: tb/gsfa_cell_test.sv
// Directed bench for the signed full adder cell: one task per scenario.
module gsfa_cell_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_x = 1'b0;
    logic in_y = 1'b0;
    logic in_z = 1'b0;

    logic r_s, r_c;
    logic s1, c1, s2, c2, s3, c3, s4, c4;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gsfa_cell #(.TYPE(1), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .sum_o(r_s), .carry_o(r_c));
    gsfa_cell #(.TYPE(1), .REG_OUT(1'b0)) u_t1 (
        .clk(clk), .rst_n(rst_n), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .sum_o(s1), .carry_o(c1));
    gsfa_cell #(.TYPE(2), .REG_OUT(1'b0)) u_t2 (
        .clk(clk), .rst_n(rst_n), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .sum_o(s2), .carry_o(c2));
    gsfa_cell #(.TYPE(3), .REG_OUT(1'b0)) u_t3 (
        .clk(clk), .rst_n(rst_n), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .sum_o(s3), .carry_o(c3));
    gsfa_cell #(.TYPE(4), .REG_OUT(1'b0)) u_t4 (
        .clk(clk), .rst_n(rst_n), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .sum_o(s4), .carry_o(c4));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_sum1(input logic x, input logic y, input logic z);
        return (x ^ ~y) ^ ~z;
    endfunction

    function automatic logic exp_carry1(input logic x, input logic y, input logic z);
        return (x & ~y) | (~y & z) | (z & x);
    endfunction

    // Weighted input value per the requirement of each type.
    function automatic int lhs(input int t, input logic x, input logic y, input logic z);
        int a, b, c;
        a = int'(x); b = int'(y); c = int'(z);
        case (t)
            1: return a - b + c;
            2: return -a + b + c;
            3: return -a - b + c;
            default: return -a - b - c;
        endcase
    endfunction

    // Weighted output value per the requirement of each type.
    function automatic int rhs(input int t, input logic s, input logic c);
        int vs, vc;
        vs = int'(s); vc = int'(c);
        case (t)
            1, 2: return 2 * vc - vs;
            3: return vs - 2 * vc;
            default: return -2 * vc - vs;
        endcase
    endfunction

    // Reset state and comb-mode independence from rst_n (R9, R7).
    task automatic t_reset();
        rst_n = 1'b0;
        in_x = 1'b1; in_y = 1'b0; in_z = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(r_s == 1'b0, "R9 reset sum", int'(r_s), 0);
        check(r_c == 1'b0, "R9 reset carry", int'(r_c), 0);
        check(s1 == 1'b1, "R7 comb sum under reset", int'(s1), 1);
        check(c1 == 1'b1, "R7 comb carry under reset", int'(c1), 1);
        rst_n = 1'b1;
    endtask

    // Type 1 gate equations and relation over all vectors (R1, R2, R3).
    task automatic t_type1_all();
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            {in_z, in_y, in_x} = 3'(v);
            #1;
            check(s1 == exp_sum1(in_x, in_y, in_z), "R2 sum", int'(s1),
                  int'(exp_sum1(in_x, in_y, in_z)));
            check(c1 == exp_carry1(in_x, in_y, in_z), "R3 carry", int'(c1),
                  int'(exp_carry1(in_x, in_y, in_z)));
            check(rhs(1, s1, c1) == lhs(1, in_x, in_y, in_z), "R1 relation",
                  rhs(1, s1, c1), lhs(1, in_x, in_y, in_z));
        end
    endtask

    // Relations of the other types over all vectors (R4, R5, R6).
    task automatic t_other_types();
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            {in_z, in_y, in_x} = 3'(v);
            #1;
            check(rhs(2, s2, c2) == lhs(2, in_x, in_y, in_z), "R4 type2 relation",
                  rhs(2, s2, c2), lhs(2, in_x, in_y, in_z));
            check(rhs(3, s3, c3) == lhs(3, in_x, in_y, in_z), "R5 type3 relation",
                  rhs(3, s3, c3), lhs(3, in_x, in_y, in_z));
            check(rhs(4, s4, c4) == lhs(4, in_x, in_y, in_z), "R6 type4 relation",
                  rhs(4, s4, c4), lhs(4, in_x, in_y, in_z));
        end
    endtask

    // Registered capture at the edge and hold between edges (R8).
    task automatic t_registered();
        for (int v = 0; v < 8; v++) begin
            logic ex, ey, ez;
            @(negedge clk);
            {in_z, in_y, in_x} = 3'(v);
            {ez, ey, ex} = 3'(v);
            @(posedge clk);
            #1;
            check(r_s == exp_sum1(ex, ey, ez), "R8 captured sum", int'(r_s),
                  int'(exp_sum1(ex, ey, ez)));
            check(r_c == exp_carry1(ex, ey, ez), "R8 captured carry", int'(r_c),
                  int'(exp_carry1(ex, ey, ez)));
            {in_z, in_y, in_x} = ~3'(v);
            #2;
            check(r_s == exp_sum1(ex, ey, ez), "R8 held sum", int'(r_s),
                  int'(exp_sum1(ex, ey, ez)));
            check(r_c == exp_carry1(ex, ey, ez), "R8 held carry", int'(r_c),
                  int'(exp_carry1(ex, ey, ez)));
        end
    endtask

    // Reset lowered mid-cycle acts only at the next edge (R9).
    task automatic t_sync_reset();
        @(negedge clk);
        in_x = 1'b1; in_y = 1'b0; in_z = 1'b0;
        @(posedge clk);
        #1;
        check(r_s == 1'b1 && r_c == 1'b1, "R9 preload both ones",
              int'({r_c, r_s}), 3);
        rst_n = 1'b0;
        #2;
        check(r_s == 1'b1 && r_c == 1'b1, "R9 no clear before edge",
              int'({r_c, r_s}), 3);
        @(posedge clk);
        #1;
        check(r_s == 1'b0 && r_c == 1'b0, "R9 clear at edge",
              int'({r_c, r_s}), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_type1_all();
        t_other_types();
        t_registered();
        t_sync_reset();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule